// File: doc/BRIEF.md
# Octal DAC Serial Command Decoder

This block is the digital front end of an eight-channel voltage DAC. A host writes 16-bit command frames over a three-wire serial link. The link has a serial clock, a data line and an active-low select. The select line also acts as the load strobe. While the select is low, each rising serial clock edge moves one data bit into a 16-bit shift register. When the select returns high, the top four bits of that register are decoded as a command. The command can write one channel, write all eight channels, do nothing, or put the converter to sleep.

The code written to the channels is the field that follows the command bits. It is sent most significant bit first, and its width is set by a parameter (8 or 10 bits). The last stage of the shift register drives a serial output, so several devices can be chained on one link. The three serial inputs are brought into the system clock domain through two-flop synchronisers, and their edges are found there.

An active-low asynchronous clear zeroes the shift register and every channel code. A synchronous reset returns the whole block to its power-up state. The outputs are the stored channel codes, a sleep flag, a one-cycle update pulse and a mask of the channels written by the last frame.

Top module: `octdac_cmd_core`

## Requirements
- R1: A rising edge of `sck_i` shifts `sdi_i` into the shift register only while `ld_n_i` is low. Edges of `sck_i` while `ld_n_i` is high have no effect on the register, on `sdo_o` or on any channel code.
- R2: The first bit of a frame ends up in frame bit 15. Bits 15..12 form the command field. The next CODE_W bits form the channel code, most significant bit first. Any bits left below the code are ignored.
- R3: On a rising edge of `ld_n_i`, command value 1 through 8 writes the code into channel 0 through 7 respectively. Channel k is held in `dac_codes_o[k*CODE_W +: CODE_W]`.
- R4: Command value 15 writes the same code into all eight channels.
- R5: Command values 0 and 9 through 13 write no channel. They clear the sleep flag.
- R6: Command value 14 sets `sleep_o` and writes no channel, whatever its code bits hold. All channel codes are kept while asleep. Any other command clears `sleep_o`.
- R7: `sdo_o` carries the bit applied to `sdi_i` sixteen accepted shifts earlier. This is the last stage of the shift register.
- R8: While `clr_n` is low, the shift register and all channel codes read zero at once, without waiting for a clock edge. `sleep_o` is not changed by the clear.
- R9: With `rst` high at a clock edge, all channel codes, `sleep_o`, `upd_o`, `upd_mask_o` and `sdo_o` become zero.
- R10: A frame with more or fewer than 16 serial clocks is decoded from the last 16 bits that were shifted in.
- R11: A load that writes channels raises `upd_o` for exactly one cycle. In that same cycle, `upd_mask_o` shows the written channels, with bit k for channel k. A load that writes no channel leaves both at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up state) |
| clr_n | input | 1 | Asynchronous active-low clear of shift register and codes |
| sck_i | input | 1 | Serial clock, asynchronous to `clk` |
| sdi_i | input | 1 | Serial data in |
| ld_n_i | input | 1 | Active-low select; its rising edge loads the frame |
| sdo_o | output | 1 | Serial data out for chaining (last shift stage) |
| dac_codes_o | output | 8*CODE_W | Eight channel codes, channel k at bits k*CODE_W upward |
| sleep_o | output | 1 | Sleep flag |
| upd_o | output | 1 | One-cycle pulse when a load wrote channels |
| upd_mask_o | output | 8 | Channels written by the last load |

## Verification
Each serial input passes through two synchroniser flops and then one action register. A shift, a channel write, a sleep change and the update pulse therefore all become visible after the third rising `clk` edge that follows the input change. The update pulse drops again after the fourth edge. The bench drives every input on a falling edge and samples exactly three falling edges later. It checks that the pulse is gone one cycle after that. Each serial clock level is held for three system cycles, so every shift is settled before the next level is driven. The clear acts without a clock, so its effect is sampled a couple of nanoseconds after `clr_n` falls.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 4;
    localparam int NUM_CH  = 8;

    localparam logic [ADDR_W-1:0] ADR_FIRST = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_ALL   = 4'hF;
    localparam logic [ADDR_W-1:0] ADR_SLEEP = 4'hE;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_ONE   = 2'd1,
        OP_ALL   = 2'd2,
        OP_SLEEP = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [NUM_CH-1:0] sel;
    } cmd_t;

    typedef struct packed {
        logic sck;
        logic din;
        logic ld_n;
    } serial_t;

    localparam serial_t SERIAL_IDLE = '{sck: 1'b0, din: 1'b0, ld_n: 1'b1};

    function automatic cmd_t decode_cmd(input logic [ADDR_W-1:0] a);
        cmd_t c;
        c.op  = OP_NOP;
        c.sel = '0;
        if (a == ADR_ALL) begin
            c.op  = OP_ALL;
            c.sel = '1;
        end else if (a == ADR_SLEEP) begin
            c.op = OP_SLEEP;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (int'(a) == int'(ADR_FIRST) + i) begin
                    c.sel[i] = 1'b1;
                    c.op     = OP_ONE;
                end
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/octdac_sync.sv
module octdac_sync
    import octdac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  serial_t d_i,
    output serial_t q_o
);
    localparam int W = $bits(serial_t);

    logic [W-1:0] d_flat;
    logic [W-1:0] q_flat;
    logic [W-1:0] idle_flat;

    assign d_flat    = d_i;
    assign idle_flat = SERIAL_IDLE;
    assign q_o       = serial_t'(q_flat);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{idle_flat[b]}};
            else     chain <= {chain[STAGES-2:0], d_flat[b]};
        end
        assign q_flat[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/octdac_edges.sv
module octdac_edges
    import octdac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  serial_t s_i,
    output logic    shift_en_o,
    output logic    load_stb_o,
    output logic    din_o
);
    logic sck_prev;
    logic ld_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= SERIAL_IDLE.sck;
            ld_prev  <= SERIAL_IDLE.ld_n;
        end else begin
            sck_prev <= s_i.sck;
            ld_prev  <= s_i.ld_n;
        end
    end

    assign shift_en_o = s_i.sck & ~sck_prev & ~s_i.ld_n;
    assign load_stb_o = s_i.ld_n & ~ld_prev;
    assign din_o      = s_i.din;

endmodule

// File: rtl/octdac_shifter.sv
module octdac_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_o,
    output logic               sdo_o
);
    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)        sr <= '0;
        else if (rst)      sr <= '0;
        else if (shift_en) sr <= {sr[FRAME_W-2:0], din};
    end

    assign frame_o = sr;
    assign sdo_o   = sr[FRAME_W-1];

endmodule

// File: rtl/octdac_bank.sv
module octdac_bank
    import octdac_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int CH     = NUM_CH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_n,
    input  logic                 load_stb,
    input  cmd_t                 cmd,
    input  logic [CODE_W-1:0]    code,
    output logic [CH*CODE_W-1:0] codes_o,
    output logic                 sleep_o,
    output logic                 upd_o,
    output logic [CH-1:0]        upd_mask_o
);
    for (genvar k = 0; k < CH; k++) begin : g_ch
        logic [CODE_W-1:0] code_q;
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)                       code_q <= '0;
            else if (rst)                     code_q <= '0;
            else if (load_stb && cmd.sel[k])  code_q <= code;
        end
        assign codes_o[k*CODE_W +: CODE_W] = code_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_o    <= 1'b0;
            upd_o      <= 1'b0;
            upd_mask_o <= '0;
        end else begin
            if (load_stb) sleep_o <= (cmd.op == OP_SLEEP);
            upd_o      <= load_stb && (cmd.op == OP_ONE || cmd.op == OP_ALL);
            upd_mask_o <= load_stb ? cmd.sel : '0;
        end
    end

endmodule

// File: rtl/octdac_cmd_core.sv
module octdac_cmd_core
    import octdac_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_n,
    input  logic                     sck_i,
    input  logic                     sdi_i,
    input  logic                     ld_n_i,
    output logic                     sdo_o,
    output logic [NUM_CH*CODE_W-1:0] dac_codes_o,
    output logic                     sleep_o,
    output logic                     upd_o,
    output logic [NUM_CH-1:0]        upd_mask_o
);
    localparam int CODE_HI = FRAME_W - ADDR_W - 1;
    localparam int PAD_W   = FRAME_W - ADDR_W - CODE_W;

    serial_t            raw_s;
    serial_t            sync_s;
    logic               shift_en;
    logic               load_stb;
    logic               din_s;
    logic [FRAME_W-1:0] frame;
    cmd_t               cmd;
    logic [CODE_W-1:0]  code;

    assign raw_s = '{sck: sck_i, din: sdi_i, ld_n: ld_n_i};

    octdac_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_s),
        .q_o (sync_s)
    );

    octdac_edges u_edges (
        .clk        (clk),
        .rst        (rst),
        .s_i        (sync_s),
        .shift_en_o (shift_en),
        .load_stb_o (load_stb),
        .din_o      (din_s)
    );

    octdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .shift_en (shift_en),
        .din      (din_s),
        .frame_o  (frame),
        .sdo_o    (sdo_o)
    );

    assign cmd  = decode_cmd(frame[FRAME_W-1 -: ADDR_W]);
    assign code = frame[CODE_HI -: CODE_W];

    if (PAD_W > 0) begin : g_pad
        logic unused_pad;
        assign unused_pad = ^frame[PAD_W-1:0];
    end

    octdac_bank #(.CODE_W(CODE_W), .CH(NUM_CH)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .load_stb   (load_stb),
        .cmd        (cmd),
        .code       (code),
        .codes_o    (dac_codes_o),
        .sleep_o    (sleep_o),
        .upd_o      (upd_o),
        .upd_mask_o (upd_mask_o)
    );

endmodule

// File: rtl/octdac_cmd_core_chk.sv
module octdac_cmd_core_chk #(
    parameter int CODE_W = 10,
    parameter int CH     = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr_n,
    input logic                 sdo_o,
    input logic [CH*CODE_W-1:0] dac_codes_o,
    input logic                 sleep_o,
    input logic                 upd_o,
    input logic [CH-1:0]        upd_mask_o
);
    // R11
    upd_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_o |=> !upd_o);

    // R3 R4
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(upd_mask_o) || upd_mask_o == '1));

    // R6
    sleep_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> upd_mask_o == '0);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_codes_o == '0 && sdo_o == 1'b0));

    for (genvar k = 0; k < CH; k++) begin : g_hold
        // R5
        ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!upd_mask_o[k] && clr_n && $past(clr_n))
                |-> $stable(dac_codes_o[k*CODE_W +: CODE_W]));
    end

endmodule

bind octdac_cmd_core octdac_cmd_core_chk #(.CODE_W(CODE_W), .CH(8)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_n       (clr_n),
    .sdo_o       (sdo_o),
    .dac_codes_o (dac_codes_o),
    .sleep_o     (sleep_o),
    .upd_o       (upd_o),
    .upd_mask_o  (upd_mask_o)
);

// File: tb/octdac_cmd_core_test.sv
module octdac_cmd_core_test;
    localparam int CW = 10;
    localparam int NC = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           clr_n = 1'b1;
    logic           sck = 1'b0;
    logic           sdi = 1'b0;
    logic           ld_n = 1'b1;
    logic           sdo;
    logic [NC*CW-1:0] codes;
    logic           sleep;
    logic           upd;
    logic [NC-1:0]  upd_mask;

    int checks = 0;
    int errors = 0;

    logic [15:0]   hist = '0;
    logic [CW-1:0] mcode [NC];
    logic          msleep = 1'b0;

    always #5 clk = ~clk;

    octdac_cmd_core #(.CODE_W(CW)) uut (
        .clk (clk), .rst (rst), .clr_n (clr_n),
        .sck_i (sck), .sdi_i (sdi), .ld_n_i (ld_n),
        .sdo_o (sdo), .dac_codes_o (codes), .sleep_o (sleep),
        .upd_o (upd), .upd_mask_o (upd_mask)
    );

    // address (4) | code (10) | pad (2)
    localparam logic [15:0] VEC [12] = '{
        {4'h1, 10'h155, 2'b00},
        {4'h8, 10'h3FF, 2'b11},
        {4'h4, 10'h001, 2'b00},
        {4'hF, 10'h2AA, 2'b01},
        {4'h2, 10'h123, 2'b10},
        {4'h0, 10'h3FF, 2'b00},
        {4'hE, 10'h0F0, 2'b00},
        {4'h5, 10'h200, 2'b00},
        {4'hB, 10'h000, 2'b00},
        {4'hE, 10'h3C3, 2'b11},
        {4'h6, 10'h0AB, 2'b00},
        {4'hD, 10'h111, 2'b00}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_codes(input string req);
        for (int k = 0; k < NC; k++)
            chk(codes[k*CW +: CW] == mcode[k], req, 32'(codes[k*CW +: CW]), 32'(mcode[k]));
    endtask

    // R1 R7: one serial clock period; sdo compared with the bench history
    task automatic sck_bit(input logic b);
        sdi = b;
        sck = 1'b0;
        wait_n(3);
        sck = 1'b1;
        wait_n(3);
        if (!ld_n) begin
            hist = {hist[14:0], b};
            chk(sdo == hist[15], "R7 sdo is 16th stage", 32'(sdo), 32'(hist[15]));
        end
        sck = 1'b0;
    endtask

    task automatic begin_frame;
        sck = 1'b0;
        wait_n(3);
        ld_n = 1'b0;
        wait_n(3);
    endtask

    // R2..R6 R11: decode the last 16 bits of the bench history
    task automatic end_frame;
        logic [3:0]    a;
        logic [CW-1:0] c;
        logic [NC-1:0] m;
        a = hist[15:12];
        c = hist[11:2];
        m = '0;
        if (a == 4'hF) m = '1;
        else if (a >= 4'h1 && a <= 4'h8) m[a - 4'h1] = 1'b1;
        ld_n = 1'b1;
        wait_n(3);
        chk(upd_mask == m, "R3 R4 R5 written-channel mask", 32'(upd_mask), 32'(m));
        chk(upd == (m != '0), "R11 update pulse", 32'(upd), 32'(m != '0));
        for (int k = 0; k < NC; k++) if (m[k]) mcode[k] = c;
        msleep = (a == 4'hE);
        check_codes("R2 R3 R4 R6 channel codes");
        chk(sleep == msleep, "R6 sleep flag", 32'(sleep), 32'(msleep));
        wait_n(1);
        chk(upd == 1'b0 && upd_mask == '0, "R11 pulse lasts one cycle", 32'(upd), 32'd0);
    endtask

    task automatic send(input logic [31:0] w, input int nbits);
        begin_frame();
        for (int i = nbits - 1; i >= 0; i--) sck_bit(w[i]);
        end_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NC; k++) mcode[k] = '0;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R9 reset state
        check_codes("R9 codes after reset");
        chk(sleep == 1'b0, "R9 sleep after reset", 32'(sleep), 32'd0);
        chk(upd == 1'b0 && upd_mask == '0, "R9 update after reset", 32'(upd_mask), 32'd0);
        chk(sdo == 1'b0, "R9 sdo after reset", 32'(sdo), 32'd0);

        // table of frames
        foreach (VEC[i]) send(32'(VEC[i]), 16);

        // R1: serial clocks with select high are ignored
        begin
            logic sdo_before;
            sdo_before = sdo;
            for (int i = 0; i < 16; i++) sck_bit(~sdo_before);
            chk(sdo == sdo_before, "R1 sck ignored while select high", 32'(sdo), 32'(sdo_before));
            check_codes("R1 codes unchanged while select high");
        end

        // R10: short frame (12 clocks) decoded from the last 16 bits
        send(32'h0000_0ABC, 12);
        // R10: long frame (20 clocks), leading bits pushed out
        send({12'h000, 4'hA, 4'h3, 10'h2F0, 2'b00}, 20);
        // R7: two chained frames, only the last one decoded
        send({4'h7, 10'h1EE, 2'b00, 4'h2, 10'h055, 2'b00}, 32);

        // R8: asynchronous clear
        @(negedge clk);
        clr_n = 1'b0;
        #2;
        for (int k = 0; k < NC; k++) mcode[k] = '0;
        hist = '0;
        check_codes("R8 clear zeroes codes");
        chk(sdo == 1'b0, "R8 clear zeroes shift register", 32'(sdo), 32'd0);
        wait_n(2);
        clr_n = 1'b1;
        wait_n(2);
        chk(sleep == msleep, "R8 clear keeps sleep", 32'(sleep), 32'(msleep));
        send({4'h3, 10'h099, 2'b00}, 16);

        // R6 then R9: sleep, then synchronous reset mid-run
        send({4'hE, 10'h3FF, 2'b00}, 16);
        @(negedge clk);
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(1);
        for (int k = 0; k < NC; k++) mcode[k] = '0;
        hist = '0;
        msleep = 1'b0;
        check_codes("R9 codes after mid-run reset");
        chk(sleep == 1'b0, "R9 sleep after mid-run reset", 32'(sleep), 32'd0);
        send({4'hF, 10'h3FF, 2'b00}, 16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule